// File: doc/BRIEF.md
# Framebuffer Control Register Block with Frame-End Interrupt

This block is the small control and status register file that sits beside a framebuffer scan-out pipeline. Software sees a byte-addressed window. It contains a control byte whose top bit arms a frame-end interrupt, and a status byte that reports whether that interrupt is pending. The status byte also reports a fixed display-type code and a colour-board flag. A run of plain byte registers holds cursor start and end, video control and similar settings that the scan-out logic reads.

The display pipeline sends a one-cycle pulse at the end of each frame. When the interrupt is armed, the pulse latches a pending flag, and that flag drives a level interrupt output. The flag stays set until software writes any value to the status byte. A read returns data combinationally in the cycle its address is presented. A write takes effect at the next clock edge. The lower half of the window belongs to another unit, so here it reads as zero and ignores writes.

Top module: `fbc_vsync_regs`

## Requirements
- R1: The control byte at offset 0x10 is read/write over all 8 bits, and its bit 7 is the interrupt arm bit.
- R2: A frame-end pulse while bit 7 of the control byte is 1 sets the pending flag, so `irq` is 1 and status bit 7 reads 1 from the next cycle.
- R3: A frame-end pulse while bit 7 of the control byte is 0 leaves the pending flag at 0.
- R4: A write of any data value to the status offset 0x11 clears the pending flag, so `irq` is 0 from the next cycle.
- R5: A read of offset 0x11 returns the pending flag in bit 7, ORed with the constant 0x61 (display-type code 0x60 and colour flag 0x01).
- R6: Offsets 0x12 to 0x1F are independent 8-bit read/write registers: 0x12 is cursor start, 0x13 is cursor end and 0x14 is video control.
- R7: Offsets 0x00 to 0x0F read as 0x00, and writes to them change no other register.
- R8: Reset drives `irq` to 0 and clears the control byte, the pending flag and the byte registers to 0.
- R9: When a status write and an armed frame-end pulse fall in the same cycle, the set wins and the flag is pending afterwards.
- R10: `irq` is a level: once pending, it stays at 1 through further frames and through clearing the arm bit, until a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| frame_end | input | 1 | One-cycle end-of-frame pulse from scan-out |
| irq | output | 1 | Level frame-end interrupt |

## Verification
The two functions that can meet in one cycle are the armed frame-end set and the software clear through a status write. The bench provokes this by driving `frame_end` and a write to 0x11 on the same clock edge, starting once from an already pending flag and once from a clear flag. It judges the result from `irq` and the status read in the following cycle, and both must show the flag pending. A separate case applies a clear alone one cycle before a frame-end pulse, so that a reversed priority or an off-by-one in the set path cannot go unnoticed.

// File: rtl/fbc_regs_pkg.sv
package fbc_regs_pkg;
   // byte offsets relative to the window (behaviour depends on them)
   localparam int unsigned CTRL_OFS    = 16;
   localparam int unsigned STAT_OFS    = 17;
   localparam int unsigned GEN_OFS     = 18;
   // bit positions
   localparam int unsigned ARM_BIT     = 7;
   localparam int unsigned PEND_BIT    = 7;
   // fixed identification bits ORed into the status read
   localparam logic [7:0]  STAT_ID     = 8'h61;
endpackage

// File: rtl/fbc_ctrl_bank.sv
module fbc_ctrl_bank
   import fbc_regs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NUM_GEN = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_hit
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

   logic [DATA_W-1:0] gen_q  [NUM_GEN];
   logic [NUM_GEN-1:0] gen_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ctrl_q <= '0;
      else if (wr && addr == CTRL_A)   ctrl_q <= wdata;
   end

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      assign gen_hit[g] = (addr == ADDR_W'(GEN_OFS + g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                gen_q[g] <= '0;
         else if (wr && gen_hit[g]) gen_q[g] <= wdata;
      end
   end

   always_comb begin
      rd_data = '0;
      rd_hit  = 1'b0;
      if (addr == CTRL_A) begin
         rd_data = ctrl_q;
         rd_hit  = 1'b1;
      end
      for (int g = 0; g < NUM_GEN; g++) begin
         if (gen_hit[g]) begin
            rd_data = gen_q[g];
            rd_hit  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fbc_vsync_pend.sv
module fbc_vsync_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_end,
   input  logic arm,
   input  logic clr,
   output logic pend
);
   logic set_now;
   assign set_now = frame_end & arm;

   // set has priority over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend <= 1'b0;
      else if (set_now) pend <= 1'b1;
      else if (clr)     pend <= 1'b0;
   end
endmodule

// File: rtl/fbc_vsync_regs.sv
module fbc_vsync_regs
   import fbc_regs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NUM_GEN = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              frame_end,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   initial begin
      if (DATA_W < 8) $error("DATA_W must be at least 8");
      if (GEN_OFS + NUM_GEN > (1 << ADDR_W)) $error("register window exceeds ADDR_W");
      if (NUM_GEN < 3) $error("NUM_GEN must cover cursor and video control bytes");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] bank_rd;
   logic              bank_hit;
   logic              int_en;
   logic              stat_wr;
   logic              pend;

   fbc_ctrl_bank #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .NUM_GEN(NUM_GEN)
   ) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .ctrl_q (ctrl_q),
      .rd_data(bank_rd),
      .rd_hit (bank_hit)
   );

   assign int_en  = ctrl_q[ARM_BIT];
   assign stat_wr = bus_wr && (bus_addr == STAT_A);

   fbc_vsync_pend pend_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_end(frame_end),
      .arm      (int_en),
      .clr      (stat_wr),
      .pend     (pend)
   );

   assign irq = pend;

   always_comb begin
      if (bus_addr == STAT_A) begin
         bus_rdata = DATA_W'(STAT_ID);
         bus_rdata[PEND_BIT] = pend;
      end else if (bank_hit) begin
         bus_rdata = bank_rd;
      end else begin
         bus_rdata = '0;
      end
   end
endmodule

// File: rtl/fbc_vsync_regs_chk.sv
module fbc_vsync_regs_chk
   import fbc_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              frame_end,
   input logic              irq,
   input logic              int_en
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

   assert_arm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && int_en) |=> irq);

   assert_disarmed_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !(frame_end && int_en)) |=> !irq);

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == STAT_A && !(frame_end && int_en)) |=> !irq);

   assert_status_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == STAT_A) |-> (bus_rdata[6:0] == STAT_ID[6:0] && bus_rdata[PEND_BIT] == irq));

   assert_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr < CTRL_A) |-> (bus_rdata == '0));

   assert_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(bus_wr && bus_addr == STAT_A)) |=> irq);

   always @(posedge clk) begin
      if (!rst_n) assert_reset_low_R8: assert (!irq);
   end
endmodule

bind fbc_vsync_regs fbc_vsync_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_rdata(bus_rdata),
   .frame_end(frame_end),
   .irq      (irq),
   .int_en   (int_en)
);

// File: tb/fbc_vsync_regs_tb_top.sv
module fbc_vsync_regs_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       frame_end = 1'b0;
   logic       irq;
   int         checks = 0;
   int         errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   fbc_vsync_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_end(frame_end), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus cycle, driven at negedge, effect visible at the next negedge
   task automatic cyc(input logic [4:0] a, input logic w, input logic [7:0] d, input logic fe);
      bus_addr = a; bus_wr = w; bus_wdata = d; frame_end = fe;
      @(negedge clk);
      bus_wr = 1'b0; frame_end = 1'b0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      cyc(a, 1'b1, d, 1'b0);
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      bus_addr = a; bus_wr = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R8 irq", {7'b0, irq}, 8'h00);
      rd(5'h10, v); chk("R8 ctrl", v, 8'h00);
      rd(5'h11, v); chk("R8 status", v, 8'h61);
      rd(5'h14, v); chk("R8 video ctrl", v, 8'h00);
   endtask

   task automatic t_ctrl();
      logic [7:0] v;
      wr(5'h10, 8'h5A); rd(5'h10, v); chk("R1 ctrl 5A", v, 8'h5A);
      wr(5'h10, 8'hA5); rd(5'h10, v); chk("R1 ctrl A5", v, 8'hA5);
      wr(5'h10, 8'h00);
   endtask

   task automatic t_gen();
      logic [7:0] v;
      for (int i = 0; i < 14; i++) wr(5'(18 + i), 8'(8'h30 + i * 7));
      for (int i = 0; i < 14; i++) begin
         rd(5'(18 + i), v); chk("R6 byte reg", v, 8'(8'h30 + i * 7));
      end
   endtask

   task automatic t_unimpl();
      logic [7:0] v;
      for (int i = 0; i < 16; i++) wr(5'(i), 8'hFF);
      rd(5'h00, v); chk("R7 low read 00", v, 8'h00);
      rd(5'h0F, v); chk("R7 low read 0F", v, 8'h00);
      rd(5'h10, v); chk("R7 ctrl untouched", v, 8'h00);
      rd(5'h12, v); chk("R7 cursor untouched", v, 8'h30);
      rd(5'h1F, v); chk("R7 last untouched", v, 8'(8'h30 + 13 * 7));
      chk("R7 irq untouched", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_disarmed();
      wr(5'h10, 8'h7F);
      cyc(5'h00, 1'b0, 8'h00, 1'b1);
      chk("R3 no pend", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_armed();
      logic [7:0] v;
      wr(5'h10, 8'h80);
      cyc(5'h00, 1'b0, 8'h00, 1'b1);
      chk("R2 irq set", {7'b0, irq}, 8'h01);
      rd(5'h11, v); chk("R2 R5 status pend", v, 8'hE1);
   endtask

   task automatic t_level();
      repeat (3) cyc(5'h00, 1'b0, 8'h00, 1'b1);
      chk("R10 stays after frames", {7'b0, irq}, 8'h01);
      wr(5'h10, 8'h00);
      repeat (2) @(negedge clk);
      chk("R10 stays after disarm", {7'b0, irq}, 8'h01);
   endtask

   task automatic t_clear();
      logic [7:0] v;
      wr(5'h11, 8'h00);
      chk("R4 cleared by 00", {7'b0, irq}, 8'h00);
      rd(5'h11, v); chk("R4 R5 status idle", v, 8'h61);
      wr(5'h10, 8'h80);
      cyc(5'h00, 1'b0, 8'h00, 1'b1);
      wr(5'h11, 8'h3C);
      chk("R4 cleared by 3C", {7'b0, irq}, 8'h00);
      // clear alone, then a frame pulse one cycle later
      cyc(5'h00, 1'b0, 8'h00, 1'b1);
      chk("R2 set after clear", {7'b0, irq}, 8'h01);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      // from pending
      cyc(5'h11, 1'b1, 8'hFF, 1'b1);
      chk("R9 set wins from pend", {7'b0, irq}, 8'h01);
      // from idle
      wr(5'h11, 8'h00);
      chk("R9 precondition idle", {7'b0, irq}, 8'h00);
      cyc(5'h11, 1'b1, 8'h80, 1'b1);
      chk("R9 set wins from idle", {7'b0, irq}, 8'h01);
      rd(5'h11, v); chk("R9 status pend", v, 8'hE1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_gen();
      t_unimpl();
      t_disarmed();
      t_armed();
      t_level();
      t_clear();
      t_collide();
      // reset mid-run with pending flag and programmed bytes
      rst_n = 1'b0;
      @(negedge clk);
      t_reset();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule